// File: doc/BRIEF.md
# Adaptive Half-Bridge Dead-Time Controller

This clocked controller turns a single PWM command into two gate-enable outputs, one for the high-side switch and one for the low-side switch of a half bridge. It never asserts both at once. The gap between them is not a fixed worst-case delay. The controller waits for feedback from two comparators: one reports that the low-side gate has discharged, the other that the switch node has fallen. After the feedback arrives, a short programmable delay covers the turn-off lag of the power device.

When PWM goes low, the high side is released after a programmable hold. The low side is then enabled once the switch node is sensed low plus a short delay, or after a timeout if that sense never arrives. Once on, the low side stays latched until PWM rises again, so ringing on the switch node cannot turn it off. An active-low disable input acts only on the low side, which lets the stage run as a non-synchronous buck. Either of two supply-good flags dropping forces both outputs off. When the supplies recover, the controller restarts from the all-off state.

Every asynchronous input passes through a two-flop synchronizer. All delays and the timeout are parameters counted in clock cycles.

Top module: `hbdt_ctrl`

## Requirements
- R1: `hi_gate` and `lo_gate` are never high in the same cycle.
- R2: After PWM rises, the low side is released first. `hi_gate` rises only after `lo_off_sense` has been seen high and `HI_ON_DLY` further cycles have passed. With the default parameters, `hi_gate` rises no earlier than the 8th clock edge after the raw PWM change.
- R3: After PWM falls, `hi_gate` stays high for exactly `HI_OFF_DLY` cycles once the synchronized level has reached the sequencer. It falls on clock edge `HI_OFF_DLY + 3` after the raw PWM change.
- R4: After the high side is released, `lo_gate` rises only after `sw_low_sense` has been seen high and `LO_ON_DLY` further cycles have passed.
- R5: If `sw_low_sense` stays low, `lo_gate` is forced high exactly `SW_TIMEOUT` cycles after `hi_gate` falls, unless the low side is disabled.
- R6: Once `lo_gate` is high, it stays high until a PWM rise is synchronized, whatever `sw_low_sense` does. Only the disable input or a supply fault can drop it earlier.
- R7: A low level on `lo_enable` turns `lo_gate` off two clock edges later and holds it off while the input stays low. `hi_gate` is not affected. With the disable held low, `hi_gate` follows PWM and `lo_gate` is 0. With it high and PWM steady, the outputs are complementary. When the disable is released during a low PWM phase, `lo_gate` comes back on.
- R8: A low on either `lo_supply_ok` or `hi_supply_ok` forces both outputs low two clock edges later.
- R9: When the supplies recover, the controller starts from all-off and follows the current PWM level through the normal hand-off, without enabling the opposite switch first.
- R10: If PWM reverses while a hand-off is pending, the pending turn-on is dropped and the opposite sequence starts. A short PWM pulse that ends before the high side is enabled produces no high-side pulse.
- R11: While `rst_n` is low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command, high selects the high-side switch |
| lo_enable | input | 1 | Active-low low-side disable, low forces `lo_gate` off |
| lo_off_sense | input | 1 | Comparator flag, high when the low-side gate is discharged |
| sw_low_sense | input | 1 | Comparator flag, high when the switch node has fallen |
| lo_supply_ok | input | 1 | Low-side supply above its undervoltage threshold |
| hi_supply_ok | input | 1 | High-side supply above its undervoltage threshold |
| hi_gate | output | 1 | High-side gate enable |
| lo_gate | output | 1 | Low-side gate enable |

## Verification
The in-line properties check the following on every cycle:
- the two outputs are never high together;
- a high-side rise is preceded by at least two cycles with the low side off;
- a latched low side survives switch-node toggling;
- the disable input and the supply flags take effect within the synchronizer latency.

The exact durations cannot be checked by these properties. That covers the hold, each turn-on delay, the timeout count, abort on PWM reversal and the restart after a supply fault. Those are shown by the bench's scenarios. A behavioural comparator plant with random response times, a sense that never arrives, and switch-node ringing drives the controller. A cycle-level reference model predicts both outputs.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

  // Sequencer phases of the half-bridge hand-off
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,  // both off, waiting for a PWM level
    PH_HI_ARM   = 3'd1,  // low side released, waiting for its off sense
    PH_HI_DELAY = 3'd2,  // settling delay before high-side turn-on
    PH_HI_ON    = 3'd3,  // high side driven
    PH_HI_HOLD  = 3'd4,  // PWM low, high side still held
    PH_LO_ARM   = 3'd5,  // high side released, waiting for switch node / timeout
    PH_LO_DELAY = 3'd6,  // settling delay before low-side turn-on
    PH_LO_ON    = 3'd7   // low side latched on
  } phase_t;

  // Input bit positions inside the synchronizer vector
  localparam int unsigned IN_PWM   = 0;
  localparam int unsigned IN_LOEN  = 1;
  localparam int unsigned IN_LOOFF = 2;
  localparam int unsigned IN_SWLOW = 3;
  localparam int unsigned IN_LOSUP = 4;
  localparam int unsigned IN_HISUP = 5;
  localparam int unsigned IN_COUNT = 6;

endpackage

// File: rtl/hbdt_sync.sv
module hbdt_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/hbdt_cycle_timer.sv
module hbdt_cycle_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // expired marks the last cycle of a window of 'limit' cycles
  assign expired = (cnt_q == limit - 1'b1);
  assign cnt_en  = clear || !expired;
  assign cnt_d   = clear ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/hbdt_ctrl.sv
module hbdt_ctrl #(
  parameter int unsigned HI_ON_DLY  = 4,
  parameter int unsigned HI_OFF_DLY = 5,
  parameter int unsigned LO_ON_DLY  = 4,
  parameter int unsigned SW_TIMEOUT = 31
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic lo_enable,
  input  logic lo_off_sense,
  input  logic sw_low_sense,
  input  logic lo_supply_ok,
  input  logic hi_supply_ok,
  output logic hi_gate,
  output logic lo_gate
);
  import hbdt_pkg::*;

  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned MAX_A  = (HI_ON_DLY > HI_OFF_DLY) ? HI_ON_DLY : HI_OFF_DLY;
  localparam int unsigned MAX_B  = (LO_ON_DLY > SW_TIMEOUT) ? LO_ON_DLY : SW_TIMEOUT;
  localparam int unsigned MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CW     = $clog2(MAX_W + 1);

  // ---------------- input synchronization ----------------
  logic [IN_COUNT-1:0] raw_in;
  logic [IN_COUNT-1:0] syn_in;

  assign raw_in[IN_PWM]   = pwm_in;
  assign raw_in[IN_LOEN]  = lo_enable;
  assign raw_in[IN_LOOFF] = lo_off_sense;
  assign raw_in[IN_SWLOW] = sw_low_sense;
  assign raw_in[IN_LOSUP] = lo_supply_ok;
  assign raw_in[IN_HISUP] = hi_supply_ok;

  hbdt_sync #(.WIDTH(IN_COUNT), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (syn_in)
  );

  logic pwm_s, en_s, loff_s, swl_s, sup_ok;
  assign pwm_s  = syn_in[IN_PWM];
  assign en_s   = syn_in[IN_LOEN];
  assign loff_s = syn_in[IN_LOOFF];
  assign swl_s  = syn_in[IN_SWLOW];
  assign sup_ok = syn_in[IN_LOSUP] & syn_in[IN_HISUP];

  // ---------------- phase timer ----------------
  phase_t        ph_q, ph_d;
  logic [CW-1:0] win_len;
  logic          win_done;
  logic          ph_change;

  always_comb begin
    case (ph_q)
      PH_HI_DELAY: win_len = CW'(HI_ON_DLY);
      PH_HI_HOLD:  win_len = CW'(HI_OFF_DLY);
      PH_LO_ARM:   win_len = CW'(SW_TIMEOUT);
      PH_LO_DELAY: win_len = CW'(LO_ON_DLY);
      default:     win_len = CW'(1);
    endcase
  end

  assign ph_change = (ph_d != ph_q);

  hbdt_cycle_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ph_change),
    .limit   (win_len),
    .expired (win_done)
  );

  // ---------------- hand-off sequencer ----------------
  always_comb begin
    ph_d = ph_q;
    if (!sup_ok) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE:     ph_d = pwm_s ? PH_HI_ARM : PH_LO_ARM;
        PH_HI_ARM: begin
          if (!pwm_s)                ph_d = PH_LO_ARM;
          else if (loff_s || !en_s)  ph_d = PH_HI_DELAY;
        end
        PH_HI_DELAY: begin
          if (!pwm_s)        ph_d = PH_LO_ARM;
          else if (win_done) ph_d = PH_HI_ON;
        end
        PH_HI_ON: begin
          if (!pwm_s) ph_d = PH_HI_HOLD;
        end
        PH_HI_HOLD: begin
          if (pwm_s)         ph_d = PH_HI_ON;
          else if (win_done) ph_d = PH_LO_ARM;
        end
        PH_LO_ARM: begin
          if (pwm_s)         ph_d = PH_HI_ARM;
          else if (swl_s)    ph_d = PH_LO_DELAY;
          else if (win_done) ph_d = PH_LO_ON;
        end
        PH_LO_DELAY: begin
          if (pwm_s)         ph_d = PH_HI_ARM;
          else if (win_done) ph_d = PH_LO_ON;
        end
        PH_LO_ON: begin
          if (pwm_s) ph_d = PH_HI_ARM;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign hi_gate = sup_ok && ((ph_q == PH_HI_ON) || (ph_q == PH_HI_HOLD));
  assign lo_gate = sup_ok && en_s && (ph_q == PH_LO_ON);

  // ---------------- assertions ----------------
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate));

  // high side rises only after the low side has been off for two cycles
  assert_lo_off_before_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate) |-> (!$past(lo_gate) && !$past(lo_gate, 2)));

  // latched low side is not dropped by switch-node activity
  assert_lo_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_gate && !pwm_s) |=> (lo_gate || !en_s || !sup_ok));

  assert_disable_cuts_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_enable |-> ##2 !lo_gate);

  assert_supply_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(lo_supply_ok && hi_supply_ok) |-> ##2 (!hi_gate && !lo_gate));

endmodule

// File: tb/hbdt_ctrl_bench.sv
module hbdt_ctrl_bench;

  localparam int HON = 4;
  localparam int HOFF = 5;
  localparam int LON = 4;
  localparam int TMO = 31;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst_n;
  logic pwm_in, lo_enable, lo_off_sense, sw_low_sense, lo_supply_ok, hi_supply_ok;
  logic hi_gate, lo_gate;

  hbdt_ctrl #(.HI_ON_DLY(HON), .HI_OFF_DLY(HOFF), .LO_ON_DLY(LON), .SW_TIMEOUT(TMO)) u_hbdt_ctrl (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .lo_enable(lo_enable),
    .lo_off_sense(lo_off_sense), .sw_low_sense(sw_low_sense),
    .lo_supply_ok(lo_supply_ok), .hi_supply_ok(hi_supply_ok),
    .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- comparator plant ----------------
  bit sw_dead = 0;   // switch-node sense never arrives
  bit ring = 0;      // switch-node sense toggles while the low side is on
  int lo_low_cnt = 0, hi_low_cnt = 0;
  int lo_dly = 2, sw_dly = 3;

  initial begin
    lo_off_sense = 1'b0;
    sw_low_sense = 1'b0;
  end

  always @(negedge clk) begin
    if (lo_gate) begin
      lo_low_cnt = 0;
      lo_dly = int'($urandom_range(1, 6));
    end else if (lo_low_cnt < 1000) lo_low_cnt++;
    lo_off_sense <= (lo_low_cnt >= lo_dly);
    if (hi_gate) begin
      hi_low_cnt = 0;
      sw_dly = int'($urandom_range(1, 8));
    end else if (hi_low_cnt < 1000) hi_low_cnt++;
    if (ring && lo_gate) sw_low_sense <= 1'($urandom_range(0, 1));
    else                 sw_low_sense <= !sw_dead && (hi_low_cnt >= sw_dly);
  end

  // ---------------- reference model ----------------
  // mode: 0 idle, 1 wait low-off, 2 hi delay, 3 hi on, 4 hi hold,
  //       5 wait switch node, 6 lo delay, 7 lo latched
  int mode = 0;
  int tick = 0;
  logic [5:0] hist[$];  // {hi_ok, lo_ok, swl, loff, en, pwm}, newest last
  logic exp_hi = 0, exp_lo = 0;

  always @(posedge clk) begin
    logic [5:0] seen, now_s;
    if (!rst_n) begin
      mode = 0; tick = 0;
      hist = {6'b0, 6'b0};
      exp_hi = 0; exp_lo = 0;
    end else begin
      seen = hist[0];  // value two edges old, as the sequencer sees it
      if (!(seen[5] && seen[4])) begin
        mode = 0;
      end else begin
        case (mode)
          0: begin mode = seen[0] ? 1 : 5; tick = 0; end
          1: if (!seen[0]) begin mode = 5; tick = 0; end
             else if (seen[2] || !seen[1]) begin mode = 2; tick = 0; end
          2: if (!seen[0]) begin mode = 5; tick = 0; end
             else if (tick == HON - 1) mode = 3;
             else tick++;
          3: if (!seen[0]) begin mode = 4; tick = 0; end
          4: if (seen[0]) mode = 3;
             else if (tick == HOFF - 1) begin mode = 5; tick = 0; end
             else tick++;
          5: if (seen[0]) mode = 1;
             else if (seen[3]) begin mode = 6; tick = 0; end
             else if (tick == TMO - 1) mode = 7;
             else tick++;
          6: if (seen[0]) mode = 1;
             else if (tick == LON - 1) mode = 7;
             else tick++;
          default: if (seen[0]) mode = 1;
        endcase
      end
      void'(hist.pop_front());
      hist.push_back({hi_supply_ok, lo_supply_ok, sw_low_sense, lo_off_sense, lo_enable, pwm_in});
      now_s = hist[0];
      exp_hi = (now_s[5] && now_s[4]) && (mode == 3 || mode == 4);
      exp_lo = (now_s[5] && now_s[4]) && now_s[1] && (mode == 7);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1", "overlap", int'(hi_gate && lo_gate), 0);
      checks++;
      if ({hi_gate, lo_gate} !== {exp_hi, exp_lo}) begin
        errors++;
        $display("FAIL R2,R4,R6,R10 model t=%0t: hi/lo actual=%b%b expected=%b%b",
                 $time, hi_gate, lo_gate, exp_hi, exp_lo);
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog expired: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- directed and random stimulus ----------------
  initial begin
    int i, bad;
    rst_n = 0; pwm_in = 0; lo_enable = 1; lo_supply_ok = 1; hi_supply_ok = 1;
    cycles(3);
    chk("R11", "hi in reset", int'(hi_gate), 0);
    chk("R11", "lo in reset", int'(lo_gate), 0);
    rst_n = 1;

    cycles(60);
    chk("R4", "lo steady on with pwm low", int'(lo_gate), 1);
    chk("R4", "hi steady off with pwm low", int'(hi_gate), 0);

    // R2: order and minimum latency of high-side turn-on
    pwm_in = 1; i = 0; bad = 0;
    do begin
      @(negedge clk); i++;
      if (hi_gate && lo_gate) bad++;
    end while (!hi_gate && i < 100);
    chk("R2", "hi reached", int'(hi_gate), 1);
    chk("R2", "hi latency >= HON+4", int'(i >= HON + 4), 1);
    cycles(30);
    chk("R2", "hi steady on", int'(hi_gate), 1);
    chk("R2", "lo steady off", int'(lo_gate), 0);

    // R3: hold time after PWM falls (2 sync + 1 phase register + HOFF)
    pwm_in = 0; i = 0;
    do begin @(negedge clk); i++; end while (hi_gate && i < 100);
    chk("R3", "hi fall sample index", i, HOFF + 3);
    i = 0;
    do begin @(negedge clk); i++; end while (!lo_gate && i < 100);
    chk("R4", "lo turns on after switch node", int'(lo_gate), 1);
    chk("R4", "lo needs at least LON cycles", int'(i >= LON + 1), 1);

    // R5: timeout when the switch-node sense never comes
    pwm_in = 1; cycles(40);
    sw_dead = 1; pwm_in = 0;
    do @(negedge clk); while (hi_gate);
    i = 0;
    do begin @(negedge clk); i++; end while (!lo_gate && i < 200);
    chk("R5", "forced lo after timeout", i, TMO);
    sw_dead = 0;

    // R6: ringing ignored while latched
    ring = 1; bad = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (!lo_gate) bad++; end
    chk("R6", "lo drops during ringing", bad, 0);
    ring = 0;

    // R7: disable pin
    lo_enable = 0;
    @(negedge clk);
    chk("R7", "lo one sample after disable", int'(lo_gate), 1);
    @(negedge clk);
    chk("R7", "lo two samples after disable", int'(lo_gate), 0);
    cycles(10);
    chk("R7", "table en0 pwm0 lo", int'(lo_gate), 0);
    chk("R7", "table en0 pwm0 hi", int'(hi_gate), 0);
    pwm_in = 1; cycles(30);
    chk("R7", "table en0 pwm1 hi", int'(hi_gate), 1);
    chk("R7", "table en0 pwm1 lo", int'(lo_gate), 0);
    pwm_in = 0; cycles(40);
    chk("R7", "disabled lo stays off", int'(lo_gate), 0);
    lo_enable = 1; cycles(4);
    chk("R7", "table en1 pwm0 lo", int'(lo_gate), 1);
    chk("R7", "table en1 pwm0 hi", int'(hi_gate), 0);

    // R8/R9: supply faults
    lo_supply_ok = 0; cycles(2);
    chk("R8", "lo off after low-side fault", int'(lo_gate), 0);
    pwm_in = 1; cycles(20);
    chk("R8", "hi held off during fault", int'(hi_gate), 0);
    lo_supply_ok = 1; bad = 0; i = 0;
    do begin
      @(negedge clk); i++;
      if (lo_gate) bad++;
    end while (!hi_gate && i < 100);
    chk("R9", "hi resumes after recovery", int'(hi_gate), 1);
    chk("R9", "no lo pulse on recovery", bad, 0);
    hi_supply_ok = 0; cycles(2);
    chk("R8", "hi off after high-side fault", int'(hi_gate), 0);
    cycles(10);
    hi_supply_ok = 1; cycles(40);
    chk("R9", "hi back on", int'(hi_gate), 1);

    // R10: reversal while waiting for the switch node
    sw_dead = 1; pwm_in = 0; cycles(HOFF + 8);
    chk("R10", "lo still pending", int'(lo_gate), 0);
    pwm_in = 1; bad = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (lo_gate) bad++; end
    chk("R10", "aborted lo never rises", bad, 0);
    chk("R10", "hi restored", int'(hi_gate), 1);
    sw_dead = 0;

    // R10: short PWM pulse before the high side can arm
    pwm_in = 0; cycles(60);
    pwm_in = 1; cycles(3); pwm_in = 0; bad = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (hi_gate) bad++; end
    chk("R10", "short pulse gives no hi", bad, 0);
    chk("R10", "lo returns after abort", int'(lo_gate), 1);

    // random traffic, checked by the model every cycle
    for (int n = 0; n < 300; n++) begin
      pwm_in = ~pwm_in;
      if ($urandom_range(0, 7) == 0) lo_enable = ~lo_enable;
      sw_dead = ($urandom_range(0, 9) == 0);
      ring = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) begin
        lo_supply_ok = 0; cycles(int'($urandom_range(1, 4))); lo_supply_ok = 1;
      end
      cycles(int'($urandom_range(1, 40)));
    end
    lo_enable = 1; sw_dead = 0; ring = 0;
    cycles(10);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule